// File: doc/BRIEF.md
# Wrapping Line Refill Controller

This block services one cache read miss at a time by filling a whole line. The line is eight words long. A miss request names the line and the word inside it that the processor is waiting for. The controller reads that word from memory first. It then steps upward through the line and wraps past the last word back to word 0, so that all eight words are fetched exactly once.

The word the processor asked for is passed straight through to the processor in the same cycle that memory returns it. The processor can therefore carry on while the rest of the line is still arriving. Each returned word is stored in its natural slot of a line buffer. When the eighth word has arrived, the whole line is presented to the cache array in natural order during a single write cycle.

The memory side is a simple request/valid port. The controller holds a word address and a request flag steady until memory answers with a valid beat. Memory may hold off any beat for as many cycles as it likes. Only one miss is in flight at a time. New requests are refused until the line write is done.

Top module: `wrap_refill_ctrl`

## Requirements
- R1: After reset, busy, mem_rd_req, cpu_valid and line_we are 0 and miss_ready is 1.
- R2: A miss is accepted only on a clock edge where miss_valid and miss_ready are both 1. While busy is high, miss_valid, miss_line and miss_off change neither the words fetched nor the line written.
- R3: The k-th beat (k = 0..7) of a refill requests mem_rd_addr = {line, (off + k) mod 8}. The word index sits in the low 3 bits and the line address in the bits above them.
- R4: cpu_valid is 1 only in the cycle where the first beat of a refill is returned (mem_rd_req and mem_rvalid both 1). In that cycle cpu_data equals mem_rdata. cpu_valid is 0 in every other cycle.
- R5: While mem_rd_req is 1 and mem_rvalid is 0, the controller keeps mem_rd_req at 1 and mem_rd_addr unchanged on the next cycle.
- R6: A refill has exactly eight accepted beats. mem_rd_req falls to 0 in the cycle after the eighth beat.
- R7: line_we is a one-cycle pulse in the cycle after the eighth beat. In that cycle line_addr equals the missed line, and line_data bits [32*i+31:32*i] hold the word with index i, for i = 0..7.
- R8: busy is 1 and miss_ready is 0 from the cycle after acceptance through the line_we cycle. Both return to idle values (busy 0, miss_ready 1) in the next cycle.
- R9: mem_rvalid is ignored while mem_rd_req is 0. It produces no cpu_valid, no line_we and no change of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | LINE_W | Line address of the miss |
| miss_off | input | OFF_W | Word offset of the missed word in the line |
| miss_ready | output | 1 | Controller idle, request can be accepted |
| busy | output | 1 | Refill in progress, including the line write cycle |
| mem_rd_req | output | 1 | Read request to memory for one word |
| mem_rd_addr | output | LINE_W+OFF_W | Word address {line, word index} of the current request |
| mem_rvalid | input | 1 | Memory returns the requested word this cycle |
| mem_rdata | input | WORD_W | Word returned by memory |
| cpu_valid | output | 1 | Missed word delivered to the processor this cycle |
| cpu_data | output | WORD_W | Missed word (zero when cpu_valid is 0) |
| line_we | output | 1 | Write the full line into the cache array |
| line_addr | output | LINE_W | Line address for the array write |
| line_data | output | WORDS*WORD_W | Full line, word i in slice i |

## Verification
Request address, early data and the request hold are all combinational on the beat. The bench therefore drives mem_rvalid and mem_rdata just after a falling edge and reads mem_rd_addr, mem_rd_req and cpu_valid one nanosecond later in the same cycle. The acceptance edge lies between two falling edges, so busy and the first request are due one cycle after miss_valid is presented. line_we and the assembled line are due exactly one cycle after the eighth valid beat, and the return to idle follows one cycle after that. The bench samples each of these in its own half-cycle and keeps a beat count of its own that advances only on driven valid beats, so random stalls of any length leave the expected addresses and data in step.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;

    // Control phases of one refill
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

endpackage

// File: rtl/wrf_beat_seq.sv
`timescale 1ns/1ps
// Tracks the start offset and beat count of a refill and yields the
// wrapped word index of the current beat.
module wrf_beat_seq #(
    parameter int WORDS = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] load_off,
    input  logic             advance,
    output logic [OFF_W-1:0] word_idx,
    output logic             first_beat,
    output logic             last_beat
);

    typedef struct packed {
        logic [OFF_W-1:0] start;
        logic [OFF_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (load) begin
            seq_d.start = load_off;
            seq_d.cnt   = '0;
        end else if (advance) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Power-of-two line length: truncating addition wraps modulo WORDS
    assign word_idx   = seq_q.start + seq_q.cnt;
    assign first_beat = (seq_q.cnt == '0);
    assign last_beat  = (seq_q.cnt == OFF_W'(WORDS - 1));

endmodule

// File: rtl/wrf_line_buf.sv
`timescale 1ns/1ps
// Line assembly buffer: each arriving word lands in its natural slot.
module wrf_line_buf #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [OFF_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_data,
    output logic [WORDS*WORD_W-1:0] line_flat
);

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_slot
        logic [WORD_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && (wr_idx == OFF_W'(gi))) begin
                slot_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign line_flat[gi*WORD_W +: WORD_W] = slot_q;
    end

endmodule

// File: rtl/wrap_refill_ctrl.sv
`timescale 1ns/1ps
// Critical-word-first line refill controller, one miss in flight.
module wrap_refill_ctrl #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    parameter int LINE_W = 27,
    localparam int OFF_W = $clog2(WORDS),
    localparam int WADR_W = LINE_W + OFF_W,
    localparam int LINE_BITS = WORDS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 miss_valid,
    input  logic [LINE_W-1:0]    miss_line,
    input  logic [OFF_W-1:0]     miss_off,
    output logic                 miss_ready,
    output logic                 busy,
    output logic                 mem_rd_req,
    output logic [WADR_W-1:0]    mem_rd_addr,
    input  logic                 mem_rvalid,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 cpu_valid,
    output logic [WORD_W-1:0]    cpu_data,
    output logic                 line_we,
    output logic [LINE_W-1:0]    line_addr,
    output logic [LINE_BITS-1:0] line_data
);

    import wrf_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic [LINE_W-1:0] line;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic             accept;
    logic             beat;
    logic [OFF_W-1:0] word_idx;
    logic             first_beat;
    logic             last_beat;

    assign accept = (ctrl_q.phase == PH_IDLE) && miss_valid;
    assign beat   = (ctrl_q.phase == PH_FETCH) && mem_rvalid;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.phase)
            PH_IDLE: begin
                if (miss_valid) begin
                    ctrl_d.phase = PH_FETCH;
                    ctrl_d.line  = miss_line;
                end
            end
            PH_FETCH: begin
                if (beat && last_beat) begin
                    ctrl_d.phase = PH_WRITE;
                end
            end
            PH_WRITE: begin
                ctrl_d.phase = PH_IDLE;
            end
            default: begin
                ctrl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{phase: PH_IDLE, line: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    wrf_beat_seq #(
        .WORDS(WORDS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_off   (miss_off),
        .advance    (beat),
        .word_idx   (word_idx),
        .first_beat (first_beat),
        .last_beat  (last_beat)
    );

    wrf_line_buf #(
        .WORD_W(WORD_W),
        .WORDS (WORDS)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (beat),
        .wr_idx    (word_idx),
        .wr_data   (mem_rdata),
        .line_flat (line_data)
    );

    // Memory request side
    assign mem_rd_req  = (ctrl_q.phase == PH_FETCH);
    assign mem_rd_addr = {ctrl_q.line, word_idx};

    // Early forwarding of the critical word, same cycle as its beat
    assign cpu_valid = beat && first_beat;
    assign cpu_data  = cpu_valid ? mem_rdata : '0;

    // Array write and status
    assign line_we    = (ctrl_q.phase == PH_WRITE);
    assign line_addr  = ctrl_q.line;
    assign miss_ready = (ctrl_q.phase == PH_IDLE);
    assign busy       = (ctrl_q.phase != PH_IDLE);

endmodule

// File: rtl/wrf_checker.sv
`timescale 1ns/1ps
module wrf_checker #(
    parameter int LINE_W = 27,
    parameter int OFF_W  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    miss_valid,
    input logic                    miss_ready,
    input logic                    busy,
    input logic                    mem_rd_req,
    input logic [LINE_W+OFF_W-1:0] mem_rd_addr,
    input logic                    mem_rvalid,
    input logic                    cpu_valid,
    input logic                    line_we
);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> (busy && mem_rd_req));

    assert_line_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && $past(mem_rd_req)) |->
            (mem_rd_addr[LINE_W+OFF_W-1:OFF_W] == $past(mem_rd_addr[LINE_W+OFF_W-1:OFF_W])));

    assert_wrap_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rvalid) |=>
            (!mem_rd_req || (mem_rd_addr[OFF_W-1:0] == OFF_W'($past(mem_rd_addr[OFF_W-1:0]) + 1'b1))));

    assert_early_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> (mem_rd_req && mem_rvalid));

    assert_early_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |=> !cpu_valid);

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rvalid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    assert_req_off_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |-> !mem_rd_req);

    assert_we_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |=> !line_we);

    assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |=> (!busy && miss_ready));

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !line_we) |=> busy);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_req |-> !cpu_valid);

endmodule

bind wrap_refill_ctrl wrf_checker #(
    .LINE_W(LINE_W),
    .OFF_W (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .busy       (busy),
    .mem_rd_req (mem_rd_req),
    .mem_rd_addr(mem_rd_addr),
    .mem_rvalid (mem_rvalid),
    .cpu_valid  (cpu_valid),
    .line_we    (line_we)
);

// File: tb/sim_wrap_refill_ctrl.sv
`timescale 1ns/1ps
module sim_wrap_refill_ctrl;

    localparam int WW = 32;
    localparam int NW = 8;
    localparam int LW = 27;
    localparam int OW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic [LW-1:0]     miss_line = '0;
    logic [OW-1:0]     miss_off = '0;
    logic              miss_ready;
    logic              busy;
    logic              mem_rd_req;
    logic [LW+OW-1:0]  mem_rd_addr;
    logic              mem_rvalid = 1'b0;
    logic [WW-1:0]     mem_rdata = '0;
    logic              cpu_valid;
    logic [WW-1:0]     cpu_data;
    logic              line_we;
    logic [LW-1:0]     line_addr;
    logic [NW*WW-1:0]  line_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wrap_refill_ctrl #(.WORD_W(WW), .WORDS(NW), .LINE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_line(miss_line), .miss_off(miss_off),
        .miss_ready(miss_ready), .busy(busy),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cpu_valid(cpu_valid), .cpu_data(cpu_data),
        .line_we(line_we), .line_addr(line_addr), .line_data(line_data)
    );

    // Memory contents model
    function automatic logic [WW-1:0] mem_word(input logic [LW-1:0] ln, input int idx);
        logic [WW-1:0] a;
        a = WW'(ln) * 32'h9E37_79B1;
        return a ^ (WW'(idx) * 32'h0100_0193) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_miss(input logic [LW-1:0] ln, input int off, input int stall, input bit poke);
        int k;
        int idx;
        bit v;
        // R9: stray valid while idle
        @(negedge clk);
        miss_valid = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata  = $urandom;
        #1;
        chk(!cpu_valid && !mem_rd_req && !busy && !line_we, "R9", "idle response to stray valid",
            {cpu_valid, mem_rd_req, busy, line_we}, 64'h0);
        @(negedge clk);
        mem_rvalid = 1'b0;
        miss_valid = 1'b1;
        miss_line  = ln;
        miss_off   = OW'(off);
        #1;
        chk(miss_ready, "R2", "ready before request", miss_ready, 1);
        @(negedge clk);
        miss_valid = poke;
        if (poke) begin
            miss_line = ~ln;
            miss_off  = OW'(off + 3);
        end
        k = 0;
        while (k < NW) begin
            v   = (($urandom % 100) >= stall);
            idx = (off + k) % NW;
            mem_rvalid = v;
            mem_rdata  = v ? mem_word(ln, idx) : $urandom;
            #1;
            chk(busy && !miss_ready, "R8", "busy during fetch", {busy, miss_ready}, 64'h2);
            chk(mem_rd_req, "R5", "request held", mem_rd_req, 1);
            chk(mem_rd_addr == {ln, OW'(idx)}, "R3", "wrapped word address",
                mem_rd_addr, {ln, OW'(idx)});
            chk(cpu_valid == (v && k == 0), "R4", "early valid", cpu_valid, (v && k == 0));
            if (v && k == 0) begin
                chk(cpu_data == mem_word(ln, idx), "R4", "early data", cpu_data, mem_word(ln, idx));
            end
            if (v) k++;
            @(negedge clk);
        end
        mem_rvalid = 1'($urandom % 2);
        mem_rdata  = $urandom;
        miss_valid = 1'b0;
        #1;
        chk(line_we, "R7", "line write pulse", line_we, 1);
        chk(!mem_rd_req, "R6", "request drops after eighth beat", mem_rd_req, 0);
        chk(busy, "R8", "busy in write cycle", busy, 1);
        chk(!cpu_valid, "R9", "no early valid in write cycle", cpu_valid, 0);
        chk(line_addr == ln, "R7", "line address", line_addr, ln);
        for (int i = 0; i < NW; i++) begin
            chk(line_data[i*WW +: WW] == mem_word(ln, i), "R7", $sformatf("line word %0d", i),
                line_data[i*WW +: WW], mem_word(ln, i));
        end
        @(negedge clk);
        mem_rvalid = 1'b0;
        #1;
        chk(!line_we, "R7", "write pulse ends", line_we, 0);
        chk(!busy && miss_ready && !mem_rd_req, "R8", "idle after write",
            {busy, miss_ready, mem_rd_req}, 64'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && miss_ready && !mem_rd_req && !cpu_valid && !line_we, "R1", "reset state",
            {busy, miss_ready, mem_rd_req, cpu_valid, line_we}, 64'h08);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!busy && miss_ready && !mem_rd_req, "R1", "state after reset release",
            {busy, miss_ready, mem_rd_req}, 64'h2);
        // Directed corners
        run_miss(27'h000_0001, 0, 0, 1'b0);
        run_miss(27'h7FF_FFFF, 7, 0, 1'b0);
        run_miss(27'h123_4567, 5, 60, 1'b1);   // R2: request poked while busy
        run_miss(27'h0AB_CDEF, 3, 85, 1'b0);
        run_miss(27'h055_5555, 1, 0, 1'b1);
        // Random misses
        for (int n = 0; n < 40; n++) begin
            run_miss(LW'($urandom), int'($urandom % NW), int'($urandom % 71), 1'($urandom % 2));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R6 watchdog expired actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule